// File: doc/BRIEF.md
# Multi-Core DVFS Transition Sequencer

This block chooses one shared performance level for a group of cores and moves the shared supply voltage and clock ratio to that level in a safe order. Each core presents a requested level and an active bit. The block takes the highest request among the active cores. When the top requestable level wins and no limit flag is raised, the block grants one extra boost level above it. A small computed table turns each level into a voltage-identifier code (`vid_req`) and a PLL ratio (`ratio_req`).

Speeding up raises the voltage first, in bounded steps, and only then changes the ratio. Slowing down changes the ratio first and then lowers the voltage. Every voltage step waits for a one-cycle `vr_ready` pulse, and every ratio change waits for a one-cycle `pll_lock` pulse. A request may change at any time, including during a transition. The block finishes the handshake in flight and then plans its next step from the voltage and ratio it holds at that moment. `cur_level` follows the target only once both axes have reached it.

Top module: `dvfs_sequencer`

## Requirements
- R1: The target level is the largest `core_req` field among cores whose `core_active` bit is 1. Core i's field is `core_req[2*i+1:2*i]`. Inactive cores are ignored whatever they request.
- R2: When no core is active, the present operating point is held. No output changes and `busy` stays 0.
- R3: When the target ratio is above the present ratio, all voltage steps up to the target code complete before `ratio_req` changes. `vid_req` and `ratio_req` never change in the same cycle.
- R4: When the target ratio is below the present ratio, `ratio_req` changes first and voltage steps down follow.
- R5: Each change of `vid_req` moves it by at most 4 codes. After a step, `vid_req` holds until `vr_ready` is seen.
- R6: After a ratio change, `ratio_req` and `vid_req` hold until `pll_lock` is seen.
- R7: A request of level 3, the top requestable level, grants boost level 4 while `limit_flag` is 0 and level 3 while it is 1. Raising `limit_flag` at boost moves the point down to level 3.
- R8: A request change during a transition takes effect after the pending handshake. The next step is computed from the present voltage and ratio.
- R9: When `vr_ready` has not arrived more than 64 cycles after a voltage step, `vr_timeout_err` rises. It stays 1 until reset, and the wait continues.
- R10: `cur_level` changes only when `vid_req` and `ratio_req` both equal the table values of the target. `busy` is 1 whenever a handshake is pending or `cur_level` differs from the target.
- R11: After reset the outputs are: `vid_req`=40, `ratio_req`=12, `cur_level`=0, `busy`=0, `vr_timeout_err`=0. The table maps level L to code 40+6L and ratio 12+4L.
- R12: `vid_req` is never below the table code of the level whose ratio is currently driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_active | input | 4 | Per-core active bit; 0 masks that core out |
| core_req | input | 8 | Per-core requested level, 2 bits per core |
| limit_flag | input | 1 | Power, current or thermal limit; blocks boost |
| vr_ready | input | 1 | One-cycle pulse: requested voltage established |
| pll_lock | input | 1 | One-cycle pulse: PLL locked at requested ratio |
| vid_req | output | 8 | Voltage-identifier code sent to the regulator |
| ratio_req | output | 8 | Frequency ratio sent to the PLL |
| cur_level | output | 3 | Level reached on both axes |
| busy | output | 1 | Transition pending or level not yet reached |
| vr_timeout_err | output | 1 | Sticky regulator handshake timeout |

## Verification
A wrong sequencing state shows up as output changes in the wrong order or with the wrong size. Examples are a ratio raised before the last voltage step, or two steps with no handshake between them. The scoreboard catches this at the first mis-ordered change, one cycle after the step is issued. A stale level or a stuck wait state shows up when `cur_level` and `busy` are checked right after the final handshake. A preemption that plans from a cached target instead of the held point produces an extra or missing step on the very next change.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_VWAIT = 2'd1,
        SEQ_FWAIT = 2'd2
    } seq_st_e;

    function automatic int unsigned lvl_code(input int unsigned lvl,
                                             input int unsigned base,
                                             input int unsigned per);
        return base + lvl * per;
    endfunction

endpackage

// File: rtl/dvfs_target_sel.sv
module dvfs_target_sel #(
    parameter int NCORES       = 4,
    parameter int NUM_REQ_LVLS = 4,
    parameter int REQ_W        = 2,
    parameter int LVL_W        = 3
) (
    input  logic [NCORES-1:0]       core_active,
    input  logic [NCORES*REQ_W-1:0] core_req,
    input  logic                    limit_flag,
    output logic [LVL_W-1:0]        tgt_lvl,
    output logic                    tgt_valid
);
    localparam logic [REQ_W-1:0] TOP_REQ = REQ_W'(NUM_REQ_LVLS - 1);
    localparam logic [LVL_W-1:0] BOOST   = LVL_W'(NUM_REQ_LVLS);

    logic [REQ_W-1:0] req_a [NCORES];
    logic [REQ_W-1:0] max_req;
    logic             any_act;

    for (genvar g = 0; g < NCORES; g++) begin : g_unpack
        assign req_a[g] = core_req[g*REQ_W +: REQ_W];
    end

    always_comb begin
        max_req = '0;
        any_act = 1'b0;
        for (int i = 0; i < NCORES; i++) begin
            if (core_active[i]) begin
                any_act = 1'b1;
                if (req_a[i] > max_req) max_req = req_a[i];
            end
        end
    end

    assign tgt_valid = any_act;
    assign tgt_lvl   = (any_act && max_req == TOP_REQ && !limit_flag) ? BOOST
                                                                      : LVL_W'(max_req);

    always_comb begin
        for (int i = 0; i < NCORES; i++) begin
            // R1
            if (core_active[i]) begin
                max_covers_chk: assert (tgt_lvl >= LVL_W'(req_a[i]));
            end
        end
        // R7
        if (limit_flag) begin
            no_boost_limited_chk: assert (tgt_lvl != BOOST);
        end
    end
endmodule

// File: rtl/dvfs_vf_map.sv
module dvfs_vf_map #(
    parameter int LVL_W       = 3,
    parameter int VID_W       = 8,
    parameter int RATIO_W     = 8,
    parameter int VID_BASE    = 40,
    parameter int VID_PER_LVL = 6,
    parameter int RATIO_BASE  = 12,
    parameter int RATIO_STEP  = 4
) (
    input  logic [LVL_W-1:0]   lvl,
    output logic [VID_W-1:0]   vid,
    output logic [RATIO_W-1:0] ratio
);
    assign vid   = VID_W'(dvfs_pkg::lvl_code(int'(lvl), VID_BASE, VID_PER_LVL));
    assign ratio = RATIO_W'(dvfs_pkg::lvl_code(int'(lvl), RATIO_BASE, RATIO_STEP));
endmodule

// File: rtl/dvfs_step_seq.sv
module dvfs_step_seq #(
    parameter int LVL_W       = 3,
    parameter int VID_W       = 8,
    parameter int RATIO_W     = 8,
    parameter int VID_BASE    = 40,
    parameter int VID_PER_LVL = 6,
    parameter int RATIO_BASE  = 12,
    parameter int RATIO_STEP  = 4,
    parameter int VID_STEP    = 4,
    parameter int TIMEOUT_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LVL_W-1:0]   goal_lvl,
    input  logic [VID_W-1:0]   goal_vid,
    input  logic [RATIO_W-1:0] goal_ratio,
    input  logic               vr_ready,
    input  logic               pll_lock,
    output logic [VID_W-1:0]   vid_req,
    output logic [RATIO_W-1:0] ratio_req,
    output logic [LVL_W-1:0]   cur_level,
    output logic               busy,
    output logic               vr_timeout_err
);
    import dvfs_pkg::*;

    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [VID_W-1:0] STEP_V  = VID_W'(VID_STEP);
    localparam logic [TMR_W-1:0] TMO_V   = TMR_W'(TIMEOUT_CYC);
    localparam logic [VID_W-1:0] RST_VID = VID_W'(VID_BASE);
    localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(RATIO_BASE);

    typedef struct packed {
        seq_st_e            st;
        logic [VID_W-1:0]   vid;
        logic [RATIO_W-1:0] ratio;
        logic [LVL_W-1:0]   lvl;
        logic [TMR_W-1:0]   tmr;
        logic               err;
    } seq_t;

    seq_t s_d, s_q;
    logic [VID_W-1:0] up_nxt, dn_nxt;

    assign up_nxt = (goal_vid - s_q.vid > STEP_V) ? s_q.vid + STEP_V : goal_vid;
    assign dn_nxt = (s_q.vid - goal_vid > STEP_V) ? s_q.vid - STEP_V : goal_vid;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SEQ_IDLE: begin
                s_d.tmr = '0;
                if (s_q.ratio < goal_ratio) begin
                    if (s_q.vid < goal_vid) begin
                        s_d.vid = up_nxt;
                        s_d.st  = SEQ_VWAIT;
                    end else begin
                        s_d.ratio = goal_ratio;
                        s_d.st    = SEQ_FWAIT;
                    end
                end else if (s_q.ratio > goal_ratio) begin
                    s_d.ratio = goal_ratio;
                    s_d.st    = SEQ_FWAIT;
                end else if (s_q.vid > goal_vid) begin
                    s_d.vid = dn_nxt;
                    s_d.st  = SEQ_VWAIT;
                end else if (s_q.vid < goal_vid) begin
                    s_d.vid = up_nxt;
                    s_d.st  = SEQ_VWAIT;
                end else begin
                    s_d.lvl = goal_lvl;
                end
            end
            SEQ_VWAIT: begin
                if (vr_ready)            s_d.st  = SEQ_IDLE;
                else if (s_q.tmr == TMO_V) s_d.err = 1'b1;
                else                     s_d.tmr = s_q.tmr + 1'b1;
            end
            SEQ_FWAIT: begin
                if (pll_lock) s_d.st = SEQ_IDLE;
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, vid: RST_VID, ratio: RST_RATIO,
                     lvl: '0, tmr: '0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign vid_req        = s_q.vid;
    assign ratio_req      = s_q.ratio;
    assign cur_level      = s_q.lvl;
    assign vr_timeout_err = s_q.err;
    assign busy           = (s_q.st != SEQ_IDLE) || (goal_lvl != s_q.lvl);

    function automatic int need_vid(input logic [RATIO_W-1:0] r);
        return VID_BASE + ((int'(r) - RATIO_BASE) / RATIO_STEP) * VID_PER_LVL;
    endfunction

    // R5
    vid_step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.vid) |-> (((s_q.vid > $past(s_q.vid)) ? s_q.vid - $past(s_q.vid)
                                                           : $past(s_q.vid) - s_q.vid) <= STEP_V));
    // R5
    vid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_VWAIT && !vr_ready) |=> $stable(s_q.vid));
    // R6
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_FWAIT && !pll_lock) |=> ($stable(s_q.ratio) && $stable(s_q.vid)));
    // R3
    one_axis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.vid) |-> $stable(s_q.ratio));
    // R12
    vid_covers_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(s_q.vid) >= need_vid(s_q.ratio));
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |=> s_q.err);
    // R10
    lvl_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.lvl) |-> (int'(s_q.ratio) == RATIO_BASE + int'(s_q.lvl) * RATIO_STEP &&
                               int'(s_q.vid) == VID_BASE + int'(s_q.lvl) * VID_PER_LVL));
endmodule

// File: rtl/dvfs_sequencer.sv
module dvfs_sequencer #(
    parameter int NCORES       = 4,
    parameter int NUM_REQ_LVLS = 4,
    parameter int VID_W        = 8,
    parameter int RATIO_W      = 8,
    parameter int VID_BASE     = 40,
    parameter int VID_PER_LVL  = 6,
    parameter int RATIO_BASE   = 12,
    parameter int RATIO_STEP   = 4,
    parameter int VID_STEP     = 4,
    parameter int TIMEOUT_CYC  = 64,
    parameter int REQ_W        = $clog2(NUM_REQ_LVLS),
    parameter int LVL_W        = $clog2(NUM_REQ_LVLS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORES-1:0]       core_active,
    input  logic [NCORES*REQ_W-1:0] core_req,
    input  logic                    limit_flag,
    input  logic                    vr_ready,
    input  logic                    pll_lock,
    output logic [VID_W-1:0]        vid_req,
    output logic [RATIO_W-1:0]      ratio_req,
    output logic [LVL_W-1:0]        cur_level,
    output logic                    busy,
    output logic                    vr_timeout_err
);
    logic [LVL_W-1:0]   tgt_lvl, goal_lvl;
    logic               tgt_valid;
    logic [VID_W-1:0]   goal_vid;
    logic [RATIO_W-1:0] goal_ratio;

    dvfs_target_sel #(
        .NCORES(NCORES), .NUM_REQ_LVLS(NUM_REQ_LVLS), .REQ_W(REQ_W), .LVL_W(LVL_W)
    ) u_sel (
        .core_active(core_active), .core_req(core_req), .limit_flag(limit_flag),
        .tgt_lvl(tgt_lvl), .tgt_valid(tgt_valid)
    );

    // with no active core the held level is its own goal
    assign goal_lvl = tgt_valid ? tgt_lvl : cur_level;

    dvfs_vf_map #(
        .LVL_W(LVL_W), .VID_W(VID_W), .RATIO_W(RATIO_W), .VID_BASE(VID_BASE),
        .VID_PER_LVL(VID_PER_LVL), .RATIO_BASE(RATIO_BASE), .RATIO_STEP(RATIO_STEP)
    ) u_map (
        .lvl(goal_lvl), .vid(goal_vid), .ratio(goal_ratio)
    );

    dvfs_step_seq #(
        .LVL_W(LVL_W), .VID_W(VID_W), .RATIO_W(RATIO_W), .VID_BASE(VID_BASE),
        .VID_PER_LVL(VID_PER_LVL), .RATIO_BASE(RATIO_BASE), .RATIO_STEP(RATIO_STEP),
        .VID_STEP(VID_STEP), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .goal_lvl(goal_lvl), .goal_vid(goal_vid),
        .goal_ratio(goal_ratio), .vr_ready(vr_ready), .pll_lock(pll_lock),
        .vid_req(vid_req), .ratio_req(ratio_req), .cur_level(cur_level),
        .busy(busy), .vr_timeout_err(vr_timeout_err)
    );

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_active == '0 && !busy) |=> ($stable(vid_req) && $stable(ratio_req)));
endmodule

// File: tb/tb_dvfs_sequencer.sv
`timescale 1ns/1ps
module tb_dvfs_sequencer;
    localparam int TMO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] core_active = '0;
    logic [7:0] core_req = '0;
    logic       limit_flag = 1'b0;
    logic       vr_ready = 1'b0;
    logic       pll_lock = 1'b0;
    logic [7:0] vid_req, ratio_req;
    logic [2:0] cur_level;
    logic       busy, vr_timeout_err;

    always #2 clk = ~clk;

    dvfs_sequencer dut (
        .clk(clk), .rst_n(rst_n), .core_active(core_active), .core_req(core_req),
        .limit_flag(limit_flag), .vr_ready(vr_ready), .pll_lock(pll_lock),
        .vid_req(vid_req), .ratio_req(ratio_req), .cur_level(cur_level),
        .busy(busy), .vr_timeout_err(vr_timeout_err)
    );

    int errors = 0, checks = 0;
    int exp_kind[$];
    int exp_val[$];
    string exp_tag[$];
    int mv = 40, mr = 12;
    bit vr_en = 1'b1, pll_en = 1'b1;

    function automatic int vid_of(int l);   return 40 + 6 * l; endfunction
    function automatic int ratio_of(int l); return 12 + 4 * l; endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(int kind, int val, string tag);
        exp_kind.push_back(kind);
        exp_val.push_back(val);
        exp_tag.push_back(tag);
    endtask

    // expected output changes for an uninterrupted move to level goal
    task automatic push_path(int goal, string tag);
        int gv = vid_of(goal);
        int gr = ratio_of(goal);
        if (mr < gr) begin
            while (mv < gv) begin mv = (gv - mv > 4) ? mv + 4 : gv; push(0, mv, tag); end
            mr = gr; push(1, mr, tag);
        end else if (mr > gr) begin
            mr = gr; push(1, mr, tag);
        end
        while (mv > gv) begin mv = (mv - gv > 4) ? mv - 4 : gv; push(0, mv, tag); end
        while (mv < gv) begin mv = (gv - mv > 4) ? mv + 4 : gv; push(0, mv, tag); end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!busy && exp_kind.size() == 0) break;
        end
    endtask

    task automatic check_point(int lvl, string tag);
        check(cur_level == 3'(lvl), {tag, " level"}, int'(cur_level), lvl);
        check(vid_req == 8'(vid_of(lvl)), {tag, " vid"}, int'(vid_req), vid_of(lvl));
        check(ratio_req == 8'(ratio_of(lvl)), {tag, " ratio"}, int'(ratio_req), ratio_of(lvl));
        check(!busy, {tag, " busy"}, int'(busy), 0);
    endtask

    // monitor: every output change must match the next scoreboard entry
    task automatic compare_evt(int kind, int val);
        checks++;
        if (exp_kind.size() == 0) begin
            errors++;
            $display("FAIL R3/R4/R5 unexpected %s change: actual=%0d expected=none",
                     kind == 0 ? "vid" : "ratio", val);
        end else begin
            int k = exp_kind.pop_front();
            int v = exp_val.pop_front();
            string t = exp_tag.pop_front();
            if (k != kind || v != val) begin
                errors++;
                $display("FAIL %s step: actual=%s %0d expected=%s %0d", t,
                         kind == 0 ? "vid" : "ratio", val, k == 0 ? "vid" : "ratio", v);
            end
        end
    endtask

    initial begin
        logic [7:0] pv, pr;
        wait (rst_n);
        @(negedge clk);
        pv = vid_req; pr = ratio_req;
        forever begin
            @(negedge clk);
            if (vid_req != pv)   compare_evt(0, int'(vid_req));
            if (ratio_req != pr) compare_evt(1, int'(ratio_req));
            pv = vid_req; pr = ratio_req;
        end
    end

    // regulator model
    initial begin
        logic [7:0] ack = 8'd40;
        forever begin
            @(negedge clk);
            if (rst_n && vr_en && vid_req != ack) begin
                repeat (2) @(negedge clk);
                vr_ready = 1'b1; ack = vid_req;
                @(negedge clk);
                vr_ready = 1'b0;
            end
        end
    end

    // PLL model
    initial begin
        logic [7:0] ack = 8'd12;
        forever begin
            @(negedge clk);
            if (rst_n && pll_en && ratio_req != ack) begin
                repeat (2) @(negedge clk);
                pll_lock = 1'b1; ack = ratio_req;
                @(negedge clk);
                pll_lock = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(vid_req == 8'd40, "R11 vid", int'(vid_req), 40);
        check(ratio_req == 8'd12, "R11 ratio", int'(ratio_req), 12);
        check(cur_level == 3'd0, "R11 level", int'(cur_level), 0);
        check(!busy && !vr_timeout_err, "R11 busy/err", int'({busy, vr_timeout_err}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: inactive core 1 asks for 3 but is masked; R3 upward order
        push_path(1, "R1/R3");
        core_req = {2'd0, 2'd0, 2'd3, 2'd1};
        core_active = 4'b0101;
        wait_idle();
        check_point(1, "R1");

        // R2: no active core holds the point
        core_active = 4'b0000;
        core_req = {2'd3, 2'd3, 2'd3, 2'd3};
        repeat (30) @(negedge clk);
        check_point(1, "R2");

        // R7: top request grants boost
        core_req = {2'd0, 2'd0, 2'd3, 2'd0};
        push_path(4, "R7/R3");
        core_active = 4'b0010;
        wait_idle();
        check_point(4, "R7 boost");

        // R7 withdrawal on limit; R4 downward order
        push_path(3, "R7/R4");
        limit_flag = 1'b1;
        wait_idle();
        check_point(3, "R7 limited");
        push_path(4, "R7 release");
        limit_flag = 1'b0;
        wait_idle();
        check_point(4, "R7 reboost");

        // R4 + R8: go down, preempt after ratio drops
        push(1, 12, "R4");
        mr = 12;
        core_req = {2'd0, 2'd0, 2'd0, 2'd0};
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (ratio_req == 8'd12) break; end
        check(cur_level == 3'd4, "R10 level held mid-move", int'(cur_level), 4);
        check(busy, "R10 busy mid-move", int'(busy), 1);
        push_path(2, "R8 down-preempt");
        core_req = {2'd0, 2'd0, 2'd2, 2'd0};
        wait_idle();
        check_point(2, "R8 down");

        // R8 upward preempt from level 0
        push_path(0, "R4");
        core_req = '0;
        wait_idle();
        check_point(0, "R4 to zero");
        push(0, 44, "R8");
        mv = 44;
        core_req = {2'd0, 2'd0, 2'd3, 2'd0};
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (vid_req == 8'd44) break; end
        check(cur_level == 3'd0 && busy, "R10 level/busy mid-ramp", int'(cur_level), 0);
        push_path(1, "R8 up-preempt");
        core_req = {2'd0, 2'd0, 2'd1, 2'd0};
        wait_idle();
        check_point(1, "R8 up");

        // R6: ratio holds until lock
        pll_en = 1'b0;
        push_path(0, "R6");
        core_req = '0;
        repeat (40) @(negedge clk);
        check(busy && cur_level == 3'd1, "R6 waiting for lock", int'(cur_level), 1);
        pll_en = 1'b1;
        wait_idle();
        check_point(0, "R6");

        // R9 timeout, R5 no step without ready
        vr_en = 1'b0;
        push(0, 44, "R9");
        mv = 44;
        core_req = {2'd0, 2'd0, 2'd1, 2'd0};
        repeat (20) @(negedge clk);
        check(!vr_timeout_err, "R9 early", int'(vr_timeout_err), 0);
        repeat (TMO + 20) @(negedge clk);
        check(vr_timeout_err, "R9 raised", int'(vr_timeout_err), 1);
        check(vid_req == 8'd44, "R5 held without ready", int'(vid_req), 44);
        push_path(1, "R9 resume");
        vr_en = 1'b1;
        wait_idle();
        check_point(1, "R9 resume");
        check(vr_timeout_err, "R9 sticky", int'(vr_timeout_err), 1);

        repeat (10) @(negedge clk);
        check(exp_kind.size() == 0, "R3 scoreboard drained", exp_kind.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule